// File: doc/BRIEF.md
# Vector memory address generator

This block turns one vector memory instruction into a stream of per-element memory requests. A start pulse captures a base address, an addressing mode, a signed byte stride, a vector length, an element width and an optional element mask. The block then walks the elements in order and, for every element that the mask leaves active, emits a byte address, the byte-lane enables inside a 64-bit memory word and the element number. The handoff uses a valid/ready handshake, and the block issues at most one request per cycle.

Three ways of forming addresses are supported. Unit stride steps by the element size. Constant stride steps by a signed byte count. Indexed mode (gather/scatter) adds a per-element byte offset to the base; the offsets arrive on a second valid/ready stream, one per element. When the block has walked every element and the last request has been taken, it raises a one-cycle done pulse and returns to idle.

Top module: `vec_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, req_valid, idx_ready, busy and done are all low.
- R2: With mode code 0 (unit stride), the request for element k carries address base + k × B. B is the element size in bytes, and width codes 0, 1, 2 and 3 give B = 1, 2, 4 and 8.
- R3: With mode code 1 (constant stride), element k has address base + k × stride. The stride is a signed two's-complement byte count, and the sum wraps modulo 2^ADDR_W.
- R4: With mode code 2 (indexed), element k has address base + index_k. Exactly one index is taken per element in element order, masked-off elements included. idx_ready is high only when idx_valid is high, and never in the other modes.
- R5: When cfg_masked is 1, an element whose bit k in cfg_mask is 0 produces no request. When cfg_masked is 0, cfg_mask has no effect and every element produces a request.
- R6: req_be has a run of B ones starting at lane L, where L is req_addr[2:0] rounded down to a multiple of B. Bit j of req_be stands for byte j of the 64-bit word.
- R7: A vector length of 0 produces no request and takes no index, and done pulses within two cycles after the start is accepted.
- R8: While req_valid is high and req_ready is low, req_valid stays high and req_addr, req_be and req_elem stay unchanged.
- R9: done is high for exactly one cycle, in the cycle after the request for the final element is accepted, and busy is low in that cycle. A start while busy is ignored, and the configuration inputs are sampled only when a start is accepted.
- R10: req_elem carries the element number k, and requests leave in increasing element order.
- R11: A vector length above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a vector; accepted only when idle |
| cfg_mode | input | 2 | 0 unit stride, 1 constant stride, 2 indexed |
| cfg_width | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| cfg_masked | input | 1 | Apply cfg_mask when 1 |
| cfg_base | input | ADDR_W (32) | Base byte address |
| cfg_stride | input | ADDR_W (32) | Signed byte stride for mode 1 |
| cfg_vl | input | VL_W (7) | Number of elements |
| cfg_mask | input | MAX_VL (64) | Per-element enable bits |
| idx_valid | input | 1 | Index stream valid |
| idx_data | input | ADDR_W (32) | Byte offset for the current element |
| idx_ready | output | 1 | Index taken this cycle |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | ADDR_W (32) | Element byte address |
| req_be | output | 8 | Byte-lane enables within the 64-bit word |
| req_elem | output | EL_W (6) | Element number |
| busy | output | 1 | A vector is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong running offset or element counter shows up on the first request after the fault as a wrong address, a wrong element number or a wrong count of requests, and the error then persists for the rest of the vector. A wrong mask or index alignment shifts every later address in an indexed vector, so the bench compares each accepted request with a value it computes itself. A control-state fault shows up within one cycle of the final handshake, as a done pulse that is missing, early, doubled or raised while a request is still pending. A fault in the output register shows up in the first stalled cycle as an address that changes under backpressure.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ewidth_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } gstate_e;

    typedef struct packed {
        amode_e  mode;
        ewidth_e width;
        logic    masked;
    } vcfg_t;

    localparam int LANES = 8;

    function automatic logic [3:0] ew_bytes(ewidth_e w);
        return 4'd1 << w;
    endfunction

    function automatic logic [LANES-1:0] lane_enables(logic [2:0] low, ewidth_e w);
        logic [LANES-1:0] r;
        case (w)
            EW_8:    r = 8'b0000_0001 << low;
            EW_16:   r = 8'b0000_0011 << {low[2:1], 1'b0};
            EW_32:   r = 8'b0000_1111 << {low[2], 2'b00};
            default: r = 8'b1111_1111;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl
    import vag_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VL_W   = 7,
    parameter int EL_W   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VL_W-1:0] vl_in,
    input  logic            need_idx,
    input  logic            idx_valid,
    input  logic            slot_free,
    output logic            accept,
    output logic            busy,
    output logic            step,
    output logic [EL_W-1:0] elem,
    output logic            done
);

    gstate_e         state_q;
    logic [EL_W-1:0] elem_q;
    logic [EL_W-1:0] lastidx_q;
    logic            done_q;
    logic [VL_W-1:0] vl_eff;
    logic [VL_W-1:0] vl_m1;
    logic            at_last;

    always_comb begin
        vl_eff = (vl_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_in;
        vl_m1  = vl_eff - VL_W'(1);
    end

    assign accept  = start && (state_q == ST_IDLE);
    assign busy    = (state_q != ST_IDLE);
    assign step    = (state_q == ST_RUN) && slot_free && (!need_idx || idx_valid);
    assign at_last = (elem_q == lastidx_q);
    assign elem    = elem_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            elem_q    <= '0;
            lastidx_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        elem_q    <= '0;
                        lastidx_q <= EL_W'(vl_m1);
                        state_q   <= (vl_eff == '0) ? ST_DRAIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (step) begin
                        if (at_last) begin
                            state_q <= ST_DRAIN;
                        end else begin
                            elem_q <= elem_q + EL_W'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    if (slot_free) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vag_agen.sv
module vag_agen
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 64,
    parameter int EL_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  vcfg_t             cfg,
    input  logic [MAX_VL-1:0] cfg_mask,
    input  logic              step,
    input  logic [EL_W-1:0]   elem,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              need_idx,
    output logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  be
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_q;
    vcfg_t             cfg_q;
    logic [MAX_VL-1:0] mask_q;
    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W-1:0] inc;

    assign need_idx = (cfg_q.mode == AM_INDEX);

    always_comb begin
        if (cfg_q.mode == AM_STRIDE) begin
            inc = stride_q;
        end else begin
            inc = {{(ADDR_W-4){1'b0}}, ew_bytes(cfg_q.width)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            stride_q <= '0;
            cfg_q    <= '{mode: AM_UNIT, width: EW_8, masked: 1'b0};
            mask_q   <= '0;
            off_q    <= '0;
        end else if (accept) begin
            base_q   <= cfg_base;
            stride_q <= cfg_stride;
            cfg_q    <= cfg;
            mask_q   <= cfg_mask;
            off_q    <= '0;
        end else if (step) begin
            off_q <= off_q + inc;
        end
    end

    assign addr   = base_q + (need_idx ? idx_data : off_q);
    assign active = !cfg_q.masked || mask_q[elem];
    assign be     = lane_enables(addr[2:0], cfg_q.width);

endmodule

// File: rtl/vag_oreg.sv
module vag_oreg
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EL_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_be,
    input  logic [EL_W-1:0]   in_elem,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LANES-1:0]  req_be,
    output logic [EL_W-1:0]   req_elem,
    output logic              slot_free
);

    assign slot_free = !req_valid || req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_be    <= '0;
            req_elem  <= '0;
        end else if (load) begin
            req_valid <= 1'b1;
            req_addr  <= in_addr;
            req_be    <= in_be;
            req_elem  <= in_elem;
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 64,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int EL_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_masked,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic [VL_W-1:0]   cfg_vl,
    input  logic [MAX_VL-1:0] cfg_mask,
    input  logic              idx_valid,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              idx_ready,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_be,
    output logic [EL_W-1:0]   req_elem,
    output logic              busy,
    output logic              done
);

    vcfg_t             cfg_in;
    logic              accept;
    logic              step;
    logic              need_idx;
    logic              active;
    logic              slot_free;
    logic [EL_W-1:0]   elem;
    logic [ADDR_W-1:0] elem_addr;
    logic [LANES-1:0]  elem_be;

    assign cfg_in = '{mode: amode_e'(cfg_mode), width: ewidth_e'(cfg_width), masked: cfg_masked};

    vag_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .EL_W(EL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vl_in     (cfg_vl),
        .need_idx  (need_idx),
        .idx_valid (idx_valid),
        .slot_free (slot_free),
        .accept    (accept),
        .busy      (busy),
        .step      (step),
        .elem      (elem),
        .done      (done)
    );

    vag_agen #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .EL_W(EL_W)) u_agen (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cfg_base   (cfg_base),
        .cfg_stride (cfg_stride),
        .cfg        (cfg_in),
        .cfg_mask   (cfg_mask),
        .step       (step),
        .elem       (elem),
        .idx_data   (idx_data),
        .need_idx   (need_idx),
        .active     (active),
        .addr       (elem_addr),
        .be         (elem_be)
    );

    vag_oreg #(.ADDR_W(ADDR_W), .EL_W(EL_W)) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .load      (step && active),
        .in_addr   (elem_addr),
        .in_be     (elem_be),
        .in_elem   (elem),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_elem  (req_elem),
        .slot_free (slot_free)
    );

    assign idx_ready = step && need_idx;

endmodule

// File: rtl/vag_checks.sv
module vag_checks #(
    parameter int ADDR_W = 32,
    parameter int EL_W   = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [7:0]        req_be,
    input logic [EL_W-1:0]   req_elem,
    input logic              idx_valid,
    input logic              idx_ready,
    input logic              busy,
    input logic              done
);

    // R8: a stalled request keeps its valid flag
    a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid);

    // R8: a stalled request keeps its payload
    a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> $stable(req_addr) && $stable(req_be) && $stable(req_elem));

    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: no request pending and not busy while done is high
    a_r9_done_clean: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid && !busy);

    // R4: an index is only taken when offered, during a vector
    a_r4_idx_gate: assert property (@(posedge clk) disable iff (rst)
        idx_ready |-> idx_valid && busy);

    // R6: the lane enables cover one whole element size
    a_r6_be_size: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones(req_be) == 1 || $countones(req_be) == 2 ||
                       $countones(req_be) == 4 || $countones(req_be) == 8));

endmodule

bind vec_addr_gen vag_checks #(.ADDR_W(ADDR_W), .EL_W(EL_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_elem  (req_elem),
    .idx_valid (idx_valid),
    .idx_ready (idx_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/vec_addr_gen_test.sv
`timescale 1ns/1ps
module vec_addr_gen_test;

    localparam int ADDR_W = 32;
    localparam int MAX_VL = 64;
    localparam int VL_W   = 7;
    localparam int EL_W   = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst;
    logic              start;
    logic [1:0]        cfg_mode;
    logic [1:0]        cfg_width;
    logic              cfg_masked;
    logic [ADDR_W-1:0] cfg_base;
    logic [ADDR_W-1:0] cfg_stride;
    logic [VL_W-1:0]   cfg_vl;
    logic [MAX_VL-1:0] cfg_mask;
    logic              idx_valid;
    logic [ADDR_W-1:0] idx_data;
    logic              idx_ready;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_be;
    logic [EL_W-1:0]   req_elem;
    logic              busy;
    logic              done;

    vec_addr_gen #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) uut (
        .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
        .cfg_masked(cfg_masked), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
        .cfg_vl(cfg_vl), .cfg_mask(cfg_mask), .idx_valid(idx_valid), .idx_data(idx_data),
        .idx_ready(idx_ready), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be), .req_elem(req_elem), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int last_done_cyc = 0;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  w;
        logic [31:0] base;
        logic [31:0] stride;
        logic [7:0]  vl;
        logic        masked;
        logic [63:0] mask;
        logic        bp;
        logic        gap;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TABLE [NV] = '{
        '{2'd0, 2'd0, 32'h0000_0100, 32'd0,          8'd9,  1'b0, 64'h0,  1'b0, 1'b0},
        '{2'd0, 2'd3, 32'h0000_2000, 32'd0,          8'd5,  1'b0, 64'h0,  1'b1, 1'b0},
        '{2'd0, 2'd1, 32'h0000_0003, 32'd0,          8'd6,  1'b0, 64'h0,  1'b0, 1'b0},
        '{2'd1, 2'd2, 32'h0000_0400, 32'd24,         8'd7,  1'b0, 64'h0,  1'b1, 1'b0},
        '{2'd1, 2'd1, 32'h0000_1000, 32'hFFFF_FFFA,  8'd8,  1'b0, 64'h0,  1'b0, 1'b0},
        '{2'd2, 2'd2, 32'h0000_8000, 32'd0,          8'd10, 1'b0, 64'h0,  1'b1, 1'b1},
        '{2'd0, 2'd2, 32'h0000_0040, 32'd0,          8'd8,  1'b1, 64'hA5, 1'b1, 1'b0},
        '{2'd2, 2'd3, 32'h0001_0000, 32'd0,          8'd5,  1'b1, 64'h06, 1'b0, 1'b1},
        '{2'd1, 2'd0, 32'h0000_0500, 32'd3,          8'd4,  1'b1, 64'h0,  1'b0, 1'b0},
        '{2'd0, 2'd0, 32'h0000_0700, 32'd0,          8'd3,  1'b0, 64'h0,  1'b0, 1'b0}
    };

    function automatic logic [31:0] idxfun(int k);
        return 32'(k * 40 + 3 * (k % 3));
    endfunction

    function automatic logic [31:0] exp_addr(vec_t v, int k);
        case (v.mode)
            2'd1:    return v.base + v.stride * 32'(k);
            2'd2:    return v.base + idxfun(k);
            default: return v.base + (32'(k) << v.w);
        endcase
    endfunction

    function automatic logic [7:0] exp_be(logic [31:0] a, logic [1:0] w);
        int nb  = 1 << w;
        int off = (int'(a[2:0]) / nb) * nb;
        return 8'(((1 << nb) - 1) << off);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke);
        int vl_eff = (v.vl > 8'(MAX_VL)) ? MAX_VL : int'(v.vl);
        int exp_k[$];
        int got = 0;
        int idx_cnt = 0;
        int cyc = 0;
        int last_hs = -10;
        bit seen_done = 0;
        bit stray_idx = 0;
        bit prev_stall = 0;
        logic [31:0] prev_addr = '0;
        string atag;
        atag = (v.mode == 2'd1) ? "R3" : (v.mode == 2'd2) ? "R4" : "R2";
        for (int k = 0; k < vl_eff; k++)
            if (!v.masked || v.mask[k]) exp_k.push_back(k);
        @(negedge clk);
        cfg_mode = v.mode; cfg_width = v.w; cfg_masked = v.masked;
        cfg_base = v.base; cfg_stride = v.stride; cfg_vl = VL_W'(v.vl); cfg_mask = v.mask;
        start = 1'b1; req_ready = 1'b0; idx_valid = 1'b0; idx_data = '0;
        @(posedge clk);
        while (!seen_done && cyc < 3000) begin
            @(negedge clk);
            start = poke && (cyc == 3);
            if (poke && cyc == 3) cfg_base = v.base + 32'h1000;
            req_ready = v.bp ? ((cyc % 3) != 1) : 1'b1;
            if (v.mode == 2'd2 && idx_cnt < vl_eff && (!v.gap || (cyc % 4) != 2)) begin
                idx_valid = 1'b1; idx_data = idxfun(idx_cnt);
            end else begin
                idx_valid = 1'b0; idx_data = '0;
            end
            #1;
            if (prev_stall)
                check(req_valid && req_addr == prev_addr, "R8", "stalled address", req_addr, prev_addr);
            prev_stall = req_valid && !req_ready;
            prev_addr  = req_addr;
            if (idx_ready && v.mode != 2'd2) stray_idx = 1;
            if (idx_valid && idx_ready) idx_cnt++;
            if (req_valid && req_ready) begin
                if (got < exp_k.size()) begin
                    int k = exp_k[got];
                    logic [31:0] ea = exp_addr(v, k);
                    check(req_elem == EL_W'(k), "R10", "element number", req_elem, k);
                    check(req_addr == ea, atag, "address", req_addr, ea);
                    check(req_be == exp_be(ea, v.w), "R6", "byte enables", req_be, exp_be(ea, v.w));
                end else begin
                    check(0, "R5", "unexpected request element", req_elem, 0);
                end
                got++;
                last_hs = cyc;
            end
            if (done) begin
                seen_done = 1;
                last_done_cyc = cyc;
            end
            cyc++;
        end
        start = 1'b0;
        check(seen_done, "R9", "done seen", seen_done, 1);
        check(got == exp_k.size(), "R5", "request count", got, exp_k.size());
        check(!stray_idx, "R4", "index taken outside indexed mode", stray_idx, 0);
        if (v.mode == 2'd2)
            check(idx_cnt == vl_eff, "R4", "indices taken", idx_cnt, vl_eff);
        if (exp_k.size() > 0 && exp_k[exp_k.size()-1] == vl_eff - 1)
            check(last_hs == last_done_cyc - 1, "R9", "done cycle after last handshake",
                  last_done_cyc, last_hs + 1);
        @(negedge clk);
        #1;
        check(!done && !busy, "R9", "done pulse length / idle", {done, busy}, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t d;
        rst = 1'b1; start = 1'b0; cfg_mode = '0; cfg_width = '0; cfg_masked = 1'b0;
        cfg_base = '0; cfg_stride = '0; cfg_vl = '0; cfg_mask = '0;
        idx_valid = 1'b0; idx_data = '0; req_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(!req_valid && !idx_ready && !busy && !done, "R1", "outputs in reset",
              {req_valid, idx_ready, busy, done}, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!req_valid && !idx_ready && !busy && !done, "R1", "outputs after reset",
              {req_valid, idx_ready, busy, done}, 0);

        for (int i = 0; i < NV; i++) run_vec(TABLE[i], 1'b0);

        // R7: zero vector length
        d = '{2'd0, 2'd2, 32'h100, 32'd0, 8'd0, 1'b0, 64'h0, 1'b0, 1'b0};
        run_vec(d, 1'b0);
        check(last_done_cyc <= 1, "R7", "done latency for empty vector", last_done_cyc, 1);
        d = '{2'd2, 2'd0, 32'h100, 32'd0, 8'd0, 1'b0, 64'h0, 1'b0, 1'b0};
        run_vec(d, 1'b0);
        check(last_done_cyc <= 1, "R7", "done latency for empty indexed vector", last_done_cyc, 1);

        // R11: length above the maximum is clamped
        d = '{2'd0, 2'd3, 32'h4000, 32'd0, 8'd100, 1'b0, 64'h0, 1'b1, 1'b0};
        run_vec(d, 1'b0);

        // R9: start and configuration changes while busy are ignored
        d = '{2'd0, 2'd1, 32'h0600, 32'd0, 8'd8, 1'b0, 64'h0, 1'b1, 1'b0};
        run_vec(d, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule